// File: doc/BRIEF.md
# Direct-Address Store Instruction Sequencer

This block is the control core for one instruction: storing the accumulator to a 16-bit address carried in the instruction itself. It owns the program counter and the accumulator. After a start pulse it asks an external bus-cycle unit for a sequence of machine cycles. First it fetches the opcode at the program counter. When the opcode is 32h, it reads two operand bytes that form the target address and then writes the accumulator there. Any other opcode finishes after its fetch and acts as a no-operation.

Every request is a single-clock pulse that carries a cycle kind and an address. The bus unit raises `done_i` on the final T-state of that cycle and, for reads, presents the byte on `rdata_i` at the same time. The sequencer counts every clock of an instruction as a T-state, wait states included. This lets the integration check the instruction length against the bus timing.

Top module: `sta_seq`

## Requirements
- R1: After reset the program counter is 0000h, `busy_o` and `req_o` are low, and the T-state count is 0.
- R2: In the clock after `start_i` is sampled high while idle, `busy_o` goes high and a request is issued with cycle kind fetch (`cyc_o` = 2'b00) at the address of the program counter.
- R3: When the fetched opcode is 32h, exactly four requests are issued, in this order: fetch, read (2'b01), read (2'b01), write (2'b10). The reads go to the next two consecutive addresses after the opcode.
- R4: The byte returned by the first operand read becomes bits 7:0 of the write address, and the byte from the second read becomes bits 15:8.
- R5: The write request presents the accumulator value on `wdata_o`.
- R6: The program counter increases by one on completion of each fetched instruction byte and changes at no other time. It ends 3 higher after a store and 1 higher after any other opcode.
- R7: `tcnt_o` is cleared at start and rises by one on every clock while busy. A store with no wait states ends at 13, a no-operation ends at 4, and each wait clock adds one.
- R8: A request lasts exactly one clock, no request is issued while idle, and no new request is issued before `done_i` ends the current machine cycle.
- R9: `start_i` has no effect while an instruction is in progress.
- R10: `acc_wr_i` loads `acc_data_i` into the accumulator only while idle. While busy the accumulator and the written byte keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one instruction at the program counter |
| acc_wr_i | input | 1 | Accumulator load strobe, honoured when idle |
| acc_data_i | input | 8 | Accumulator load value |
| done_i | input | 1 | Last T-state of the current machine cycle |
| rdata_i | input | 8 | Byte read by the bus unit, valid with done_i |
| req_o | output | 1 | One-clock machine-cycle request |
| cyc_o | output | 2 | Cycle kind: 00 fetch, 01 read, 10 write |
| addr_o | output | 16 | Address of the requested cycle |
| wdata_o | output | 8 | Data for a write cycle |
| busy_o | output | 1 | Instruction in progress |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |
| tcnt_o | output | 8 | T-states spent by the current or last instruction |

## Verification
Two things can meet in one clock: an accumulator load and the write cycle that stores the accumulator. The bench provokes this by raising `acc_wr_i` in the very clock where the write request appears, while also holding `start_i` high through the whole instruction. It judges the result at the ports. The written byte must be the old accumulator value, `acc_o` must stay unchanged once the sequencer is idle, and exactly four requests must have been seen. The sweep also stretches every machine cycle by zero to two wait clocks. This shows that the T-state total and the request order follow `done_i` and not a fixed count.

// File: rtl/sta_pkg.sv
package sta_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_OPER,
    ST_WRITE
  } st_e;
endpackage

// File: rtl/sta_tcount.sv
module sta_tcount #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + TW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sta_addr_asm.sv
module sta_addr_asm #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int NL = AW / DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] lane_we_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o
);
  // lane 0 is the first operand byte read, i.e. the least significant byte
  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [DW-1:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          seg_q <= '0;
      else if (lane_we_i[k]) seg_q <= rdata_i;
    end
    assign addr_o[k*DW +: DW] = seg_q;
  end
endmodule

// File: rtl/sta_ctrl.sv
module sta_ctrl
  import sta_pkg::*;
#(
  parameter int          AW  = 16,
  parameter int          DW  = 8,
  parameter logic [7:0]  OPC = 8'h32,
  localparam int NL = AW / DW,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  output st_e           st_o,
  output logic          busy_o,
  output logic          req_o,
  output logic          launch_o,
  output logic          pc_inc_o,
  output logic [NL-1:0] lane_we_o
);
  st_e           st_q, st_d;
  logic          first_q;
  logic [LW-1:0] lane_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: if (done_i)  st_d = (rdata_i[7:0] == OPC) ? ST_OPER : ST_IDLE;
      ST_OPER:  if (done_i && lane_q == LW'(NL-1)) st_d = ST_WRITE;
      ST_WRITE: if (done_i)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      lane_q  <= '0;
    end else begin
      st_q <= st_d;
      // T1 of a machine cycle follows either a start or a finished cycle
      if (st_q == ST_IDLE)   first_q <= start_i;
      else if (done_i)       first_q <= (st_d != ST_IDLE);
      else                   first_q <= 1'b0;
      if (st_q == ST_FETCH)                    lane_q <= '0;
      else if (st_q == ST_OPER && done_i)      lane_q <= lane_q + LW'(1);
    end
  end

  assign st_o     = st_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign req_o    = busy_o && first_q;
  assign launch_o = (st_q == ST_IDLE) && start_i;
  assign pc_inc_o = done_i && (st_q == ST_FETCH || st_q == ST_OPER);

  for (genvar k = 0; k < NL; k++) begin : g_we
    assign lane_we_o[k] = done_i && (st_q == ST_OPER) && (lane_q == LW'(k));
  end
endmodule

// File: rtl/sta_seq.sv
module sta_seq
  import sta_pkg::*;
#(
  parameter int         AW      = 16,
  parameter int         DW      = 8,
  parameter int         TW      = 8,
  parameter logic [7:0] OPC_STA = 8'h32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          acc_wr_i,
  input  logic [DW-1:0] acc_data_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic [1:0]    cyc_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [TW-1:0] tcnt_o
);
  localparam int NL = AW / DW;

  st_e           st;
  logic          launch, pc_inc;
  logic [NL-1:0] lane_we;
  logic [AW-1:0] tgt_addr;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] acc_q;

  sta_ctrl #(.AW(AW), .DW(DW), .OPC(OPC_STA)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .done_i   (done_i),
    .rdata_i  (rdata_i),
    .st_o     (st),
    .busy_o   (busy_o),
    .req_o    (req_o),
    .launch_o (launch),
    .pc_inc_o (pc_inc),
    .lane_we_o(lane_we)
  );

  sta_addr_asm #(.AW(AW), .DW(DW)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_we_i(lane_we),
    .rdata_i  (rdata_i),
    .addr_o   (tgt_addr)
  );

  sta_tcount #(.TW(TW)) u_tcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .inc_i (busy_o),
    .cnt_o (tcnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (pc_inc) pc_q <= pc_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  acc_q <= '0;
    else if (acc_wr_i && !busy_o) acc_q <= acc_data_i;
  end

  always_comb begin
    unique case (st)
      ST_OPER:  cyc_o = CYC_READ;
      ST_WRITE: cyc_o = CYC_WRITE;
      default:  cyc_o = CYC_FETCH;
    endcase
  end

  assign addr_o  = (st == ST_WRITE) ? tgt_addr : pc_q;
  assign wdata_o = acc_q;
  assign pc_o    = pc_q;
  assign acc_o   = acc_q;
endmodule

// File: rtl/sta_seq_chk.sv
module sta_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_i,
  input logic          req_o,
  input logic [1:0]    cyc_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] wdata_o,
  input logic          busy_o,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o,
  input logic [TW-1:0] tcnt_o
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o); // R8
  AST_NO_REQ_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> !req_o); // R8
  AST_FETCH_AT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cyc_o == 2'b00) |-> addr_o == pc_o); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(pc_o)); // R6
  AST_ACC_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(acc_o)); // R10
  AST_TCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> tcnt_o == TW'($past(tcnt_o) + TW'(1))); // R7
  AST_WRITE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cyc_o == 2'b10) |-> wdata_o == acc_o); // R5
endmodule

bind sta_seq sta_seq_chk #(.AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .done_i (done_i),
  .req_o  (req_o),
  .cyc_o  (cyc_o),
  .addr_o (addr_o),
  .wdata_o(wdata_o),
  .busy_o (busy_o),
  .pc_o   (pc_o),
  .acc_o  (acc_o),
  .tcnt_o (tcnt_o)
);

// File: tb/tb_sta_seq.sv
`timescale 1ns/1ps
module tb_sta_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_data = '0;
  logic        done = 1'b0;
  logic [7:0]  rdata = '0;
  logic        req;
  logic [1:0]  cyc;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        busy;
  logic [15:0] pc;
  logic [7:0]  acc;
  logic [7:0]  tcnt;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [256];
  int          wait_n = 0;
  int          rem = 0;
  bit          active = 0;
  int          log_n = 0;
  logic [1:0]  log_cyc [8];
  logic [15:0] log_addr [8];
  logic [7:0]  log_wd [8];

  always #2.5 clk = ~clk;

  sta_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_wr_i(acc_wr),
    .acc_data_i(acc_data), .done_i(done), .rdata_i(rdata), .req_o(req),
    .cyc_o(cyc), .addr_o(addr), .wdata_o(wdata), .busy_o(busy), .pc_o(pc),
    .acc_o(acc), .tcnt_o(tcnt)
  );

  // bus-cycle unit model: done on the last T-state, fetch 4 T, others 3 T
  always @(negedge clk) begin
    if (done) active = 0;
    if (req) begin
      if (log_n < 8) begin
        log_cyc[log_n]  = cyc;
        log_addr[log_n] = addr;
        log_wd[log_n]   = wdata;
      end
      log_n++;
      active = 1;
      rem    = ((cyc == 2'b00) ? 4 : 3) - 1 + wait_n;
      rdata  = mem[addr[7:0]];
    end else if (active && rem > 0) begin
      rem--;
    end
    done = active && !req && rem == 0;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic load_acc(input logic [7:0] v);
    @(negedge clk); acc_wr = 1'b1; acc_data = v;
    @(negedge clk); acc_wr = 1'b0;
  endtask

  task automatic run_one();
    log_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] p;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(pc == 16'h0000, "R1 pc", pc, 0);
    chk(!busy && !req, "R1 busy/req", {busy, req}, 0);
    chk(tcnt == 8'd0, "R1 tcnt", tcnt, 0);

    // start: fetch request appears one clock later at the PC
    mem[0] = 8'h00;
    log_n = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && req && cyc == 2'b00 && addr == 16'h0000, "R2 fetch issue", {busy, req, cyc, addr}, 32'h1_1_0_0000);
    while (busy) @(negedge clk);
    chk(log_n == 1, "R3 nop count", log_n, 1);
    chk(pc == 16'h0001, "R6 nop pc", pc, 1);
    chk(tcnt == 8'd4, "R7 nop tcnt", tcnt, 4);

    // sweep: stores with varied operands, accumulator and wait states
    for (int i = 0; i < 9; i++) begin
      logic [7:0] lo, hi, av;
      p  = pc;
      lo = 8'(i * 37 + 5);
      hi = 8'(i * 53 + 16);
      av = 8'(i * 29 + 3);
      mem[p[7:0]]        = 8'h32;
      mem[8'(p[7:0] + 1)] = lo;
      mem[8'(p[7:0] + 2)] = hi;
      wait_n = i % 3;
      load_acc(av);
      chk(acc == av, "R10 idle load", acc, av);
      run_one();
      chk(log_n == 4, "R3 count", log_n, 4);
      chk(log_cyc[0] == 2'b00 && log_cyc[1] == 2'b01 && log_cyc[2] == 2'b01 && log_cyc[3] == 2'b10,
          "R3 order", {log_cyc[0], log_cyc[1], log_cyc[2], log_cyc[3]}, 8'b00_01_01_10);
      chk(log_addr[0] == p && log_addr[1] == 16'(p + 1) && log_addr[2] == 16'(p + 2),
          "R3 addrs", log_addr[2], 16'(p + 2));
      chk(log_addr[3] == {hi, lo}, "R4 target", log_addr[3], {hi, lo});
      chk(log_wd[3] == av, "R5 wdata", log_wd[3], av);
      chk(pc == 16'(p + 3), "R6 pc", pc, 16'(p + 3));
      chk(tcnt == 8'(13 + 4 * wait_n), "R7 tcnt", tcnt, 8'(13 + 4 * wait_n));
    end

    // acc load and start held during a store; load lands with the write request
    wait_n = 1;
    p = pc;
    mem[p[7:0]]         = 8'h32;
    mem[8'(p[7:0] + 1)] = 8'h34;
    mem[8'(p[7:0] + 2)] = 8'h12;
    load_acc(8'hA5);
    log_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    while (!(req && cyc == 2'b10)) @(negedge clk);
    acc_wr = 1'b1; acc_data = 8'h5A; start = 1'b0;
    @(negedge clk); acc_wr = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(log_n == 4, "R9 single instr", log_n, 4);
    chk(!busy, "R9 idle after", busy, 0);
    chk(log_wd[3] == 8'hA5, "R10 written byte", log_wd[3], 8'hA5);
    chk(acc == 8'hA5, "R10 acc kept", acc, 8'hA5);
    chk(log_addr[3] == 16'h1234, "R4 target", log_addr[3], 16'h1234);
    chk(pc == 16'(p + 3), "R6 pc", pc, 16'(p + 3));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule